// File: doc/BRIEF.md
# Auxiliary Video Information Packet Scheduler

This block holds the payload of a periodic auxiliary video information packet and decides when that packet goes out on a digital display link. Software writes four 32-bit content words and a small control register through a simple write port. The content words are a staging area only. The words that are actually sent sit in a separate transmit shadow. That shadow is reloaded only when software asks for it with a self-clearing update command, and only at a frame boundary.

At each qualifying frame-start strobe the block loads the 128-bit packet into its output register and raises a valid flag toward a downstream packet inserter. The flag stays high until the inserter signals ready. A control bit selects between sending every frame and sending every second frame. In the every-second-frame mode a parity toggle chooses which frames qualify. Turning the enable on restarts that toggle, so the first frame after enabling always transmits. If a frame strobe arrives while the previous packet is still waiting for ready, that frame's packet is dropped and not queued.

Top module: `ifp_sched`

## Requirements
- R1: The write port stores data at address 0..3 into content words 0..3 and data at address 4 into the control register. The control readback `ctrl_rd` is {update pending (bit 2), rate (bit 1), enable (bit 0)}. It reflects a write in the cycle after that write.
- R2: Writing a 1 to control bit 2 sets the update-pending flag. The flag reads 1 until the next frame-start strobe and then clears by itself, unless the same cycle rewrites it to 1.
- R3: At a frame-start strobe with update pending, the shadow takes the current content words. Word k occupies `pkt_data` bits [32k+31:32k]. A packet launched on that same strobe already carries the new words.
- R4: Content writes that have no following update command do not change the packet data that is transmitted.
- R5: With the enable bit (control bit 0) at 0, a frame-start strobe launches no packet.
- R6: With rate bit (control bit 1) at 0 and enable at 1, every frame-start strobe that finds no packet waiting launches one.
- R7: With rate bit 1, enabled strobes alternate between transmitting and not transmitting. The first strobe after the enable goes from 0 to 1 transmits.
- R8: `pkt_valid` rises in the cycle after the launching strobe. It holds with stable `pkt_data` while `pkt_ready` is low, and falls in the cycle after a cycle with `pkt_ready` high.
- R9: A frame-start strobe that finds `pkt_valid` high is skipped without queuing. The every-second-frame parity still advances on it.
- R10: After reset, `pkt_valid` is 0, `ctrl_rd` is 0, and the shadow holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0..3 content words, 4 control |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| pkt_ready | input | 1 | Inserter accepts the presented packet |
| pkt_valid | output | 1 | A packet is presented |
| pkt_data | output | 128 | Packet payload, word 0 in the low bits |
| ctrl_rd | output | 3 | Control readback {update pending, rate, enable} |

## Verification
The scheduler is driven with widely spaced frame strobes and an always-ready inserter, so that every-frame and every-second-frame rates show up as distinct launch patterns. Content is rewritten both with and without an update command. This separates a correct shadow from one that follows the staging words directly. An inserter that stalls across several strobes shows whether a blocked frame is dropped or queued, and whether the parity keeps counting through it. Enable is toggled off and on in the middle of an alternating sequence to confirm that the parity restarts on the transmitting frame.

// File: rtl/ifp_pkg.sv
package ifp_pkg;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_RATE_BIT = 1;
  localparam int CTRL_UPD_BIT  = 2;

  typedef struct packed {
    logic upd;
    logic rate;
    logic en;
  } ifp_ctrl_t;
endpackage

// File: rtl/ifp_regs.sv
module ifp_regs
  import ifp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 3,
  localparam int PKT_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_start,
  output logic [PKT_W-1:0]  content,
  output ifp_ctrl_t         ctrl,
  output logic              en_rise
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(WORDS);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  assign en_rise = ctrl_wr && wr_data[CTRL_EN_BIT] && !ctrl.en;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        content[k*DATA_W +: DATA_W] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(k))
        content[k*DATA_W +: DATA_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.en   <= wr_data[CTRL_EN_BIT];
        ctrl.rate <= wr_data[CTRL_RATE_BIT];
      end
      if (ctrl_wr && wr_data[CTRL_UPD_BIT])
        ctrl.upd <= 1'b1;
      else if (frame_start)
        ctrl.upd <= 1'b0;
    end
  end
endmodule

// File: rtl/ifp_shadow.sv
module ifp_shadow #(
  parameter int PKT_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             upd,
  input  logic [PKT_W-1:0] content,
  output logic [PKT_W-1:0] next_pkt
);
  logic [PKT_W-1:0] shadow;

  // The word set for a launch on this strobe is the one after any copy.
  assign next_pkt = upd ? content : shadow;

  always_ff @(posedge clk) begin
    if (rst)
      shadow <= '0;
    else if (frame_start && upd)
      shadow <= content;
  end
endmodule

// File: rtl/ifp_launch.sv
module ifp_launch #(
  parameter int PKT_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             en,
  input  logic             rate,
  input  logic             en_rise,
  input  logic             pkt_ready,
  input  logic [PKT_W-1:0] next_pkt,
  output logic             pkt_valid,
  output logic [PKT_W-1:0] pkt_data
);
  logic skip_phase;
  logic launch;

  assign launch = frame_start && en && (!rate || !skip_phase) && !pkt_valid;

  always_ff @(posedge clk) begin
    if (rst)
      skip_phase <= 1'b0;
    else if (en_rise)
      skip_phase <= 1'b0;
    else if (frame_start && en)
      skip_phase <= !skip_phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid <= 1'b0;
      pkt_data  <= '0;
    end else if (launch) begin
      pkt_valid <= 1'b1;
      pkt_data  <= next_pkt;
    end else if (pkt_valid && pkt_ready) begin
      pkt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ifp_sched.sv
module ifp_sched
  import ifp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 3,
  localparam int PKT_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              frame_start,
  input  logic              pkt_ready,
  output logic              pkt_valid,
  output logic [PKT_W-1:0]  pkt_data,
  output logic [2:0]        ctrl_rd
);
  logic [PKT_W-1:0] content;
  logic [PKT_W-1:0] next_pkt;
  ifp_ctrl_t        ctrl;
  logic             en_rise;

  ifp_regs #(.DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .content(content), .ctrl(ctrl), .en_rise(en_rise)
  );

  ifp_shadow #(.PKT_W(PKT_W)) u_shadow (
    .clk(clk), .rst(rst), .frame_start(frame_start), .upd(ctrl.upd),
    .content(content), .next_pkt(next_pkt)
  );

  ifp_launch #(.PKT_W(PKT_W)) u_launch (
    .clk(clk), .rst(rst), .frame_start(frame_start), .en(ctrl.en),
    .rate(ctrl.rate), .en_rise(en_rise), .pkt_ready(pkt_ready),
    .next_pkt(next_pkt), .pkt_valid(pkt_valid), .pkt_data(pkt_data)
  );

  assign ctrl_rd = ctrl;
endmodule

// File: rtl/ifp_sched_chk.sv
module ifp_sched_chk #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 3,
  localparam int PKT_W = DATA_W * WORDS
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              frame_start,
  input logic              pkt_ready,
  input logic              pkt_valid,
  input logic [PKT_W-1:0]  pkt_data,
  input logic [2:0]        ctrl_rd
);
  logic upd_wr;
  assign upd_wr = wr_en && (wr_addr == ADDR_W'(WORDS)) && wr_data[2];

  assert_hold_until_ready_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_data));

  assert_drop_after_ready_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_valid && pkt_ready |=> !pkt_valid);

  assert_no_send_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid && !ctrl_rd[0] |=> !pkt_valid);

  assert_launch_on_frame_R6: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid && !frame_start |=> !pkt_valid);

  assert_update_clears_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start && !upd_wr |=> !ctrl_rd[2]);

  assert_update_sets_R2: assert property (@(posedge clk) disable iff (rst)
    upd_wr |=> ctrl_rd[2]);
endmodule

bind ifp_sched ifp_sched_chk #(.DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .frame_start(frame_start), .pkt_ready(pkt_ready), .pkt_valid(pkt_valid),
  .pkt_data(pkt_data), .ctrl_rd(ctrl_rd)
);

// File: tb/ifp_sched_bench.sv
module ifp_sched_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         frame_start = 1'b0;
  logic         pkt_ready = 1'b0;
  logic         pkt_valid;
  logic [127:0] pkt_data;
  logic [2:0]   ctrl_rd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int launches = 0;

  // reference model state
  logic [31:0]  m_cont [4];
  logic [127:0] m_shadow;
  logic [127:0] m_data;
  logic         m_en, m_rate, m_pend, m_par, m_valid;

  always #10 clk = ~clk;

  ifp_sched u_ifp_sched (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .pkt_ready(pkt_ready), .pkt_valid(pkt_valid),
    .pkt_data(pkt_data), .ctrl_rd(ctrl_rd)
  );

  function automatic logic [127:0] cat_cont();
    return {m_cont[3], m_cont[2], m_cont[1], m_cont[0]};
  endfunction

  always @(posedge clk) begin
    logic [127:0] src;
    logic         launch, ctrl_w, rise;
    cycles++;
    if (rst) begin
      for (int k = 0; k < 4; k++) m_cont[k] = '0;
      m_shadow = '0; m_data = '0;
      m_en = 0; m_rate = 0; m_pend = 0; m_par = 0; m_valid = 0;
    end else begin
      ctrl_w = wr_en && wr_addr == 3'd4;
      rise   = ctrl_w && wr_data[0] && !m_en;
      src    = m_pend ? cat_cont() : m_shadow;
      launch = frame_start && m_en && (!m_rate || !m_par) && !m_valid;
      if (frame_start && m_pend) m_shadow = cat_cont();
      if (launch) begin
        m_valid = 1; m_data = src; launches++;
      end else if (m_valid && pkt_ready) m_valid = 0;
      if (rise) m_par = 0;
      else if (frame_start && m_en) m_par = !m_par;
      if (ctrl_w && wr_data[2]) m_pend = 1;
      else if (frame_start) m_pend = 0;
      if (ctrl_w) begin m_en = wr_data[0]; m_rate = wr_data[1]; end
      if (wr_en && wr_addr < 3'd4) m_cont[wr_addr[1:0]] = wr_data;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (ctrl_rd !== {m_pend, m_rate, m_en}) begin
        errors++;
        $display("FAIL R1/R2 ctrl_rd actual=%b expected=%b", ctrl_rd, {m_pend, m_rate, m_en});
      end
      checks++;
      if (pkt_valid !== m_valid) begin
        errors++;
        $display("FAIL R5-R9 valid: pkt_valid actual=%b expected=%b t=%0t", pkt_valid, m_valid, $time);
      end
      if (m_valid) begin
        checks++;
        if (pkt_data !== m_data) begin
          errors++;
          $display("FAIL R3/R4 pkt_data actual=%h expected=%h", pkt_data, m_data);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic frame(input int gap);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_launches(input int exp, input string tag);
    checks++;
    if (launches !== exp) begin
      errors++;
      $display("FAIL %s launch count actual=%0d expected=%0d", tag, launches, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    checks++;
    if (pkt_valid !== 0 || ctrl_rd !== 0) begin
      errors++;
      $display("FAIL R10 valid=%b ctrl=%b expected 0/0", pkt_valid, ctrl_rd);
    end
    pkt_ready = 1;
    // R5: disabled, no packets
    frame(3); frame(3);
    expect_launches(0, "R5");
    // R1, R2, R3: load words, update, enable every-frame
    for (int k = 0; k < 4; k++) wr(3'(k), 32'hA000_0000 + 32'(k * 17));
    wr(3'd4, 32'h5);
    frame(4);
    // R6: every frame transmits
    frame(4); frame(4);
    expect_launches(3, "R6");
    // R4: content rewritten without update
    for (int k = 0; k < 4; k++) wr(3'(k), 32'h1234_0000 + 32'(k));
    frame(4); frame(4);
    // R3: update picked up at next strobe, same-strobe packet uses new words
    wr(3'd4, 32'h5);
    frame(4);
    expect_launches(6, "R3");
    // R7: every second frame
    wr(3'd4, 32'h3);
    frame(3); frame(3); frame(3); frame(3);
    // R7: re-enable restarts parity at transmitting frame
    wr(3'd4, 32'h2);
    wr(3'd4, 32'h3);
    frame(3); frame(3); frame(3);
    // R8, R9: stalled inserter, frames skipped, parity still counts
    wr(3'd4, 32'h1);
    pkt_ready = 0;
    frame(3); frame(3); frame(3);
    repeat (4) @(negedge clk);
    pkt_ready = 1;
    repeat (2) @(negedge clk);
    frame(3);
    wr(3'd4, 32'h3);
    pkt_ready = 0;
    frame(2); frame(2); frame(2);
    pkt_ready = 1;
    frame(2); frame(2); frame(2);
    // R2: update written in the strobe cycle stays pending
    @(negedge clk); frame_start = 1; wr_en = 1; wr_addr = 3'd4; wr_data = 32'h5;
    @(negedge clk); frame_start = 0; wr_en = 0;
    frame(2); frame(2);
    // R5: disabled again
    wr(3'd4, 32'h0);
    frame(2); frame(2);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule